// File: doc/BRIEF.md
# Load-Use Hazard Stall Controller

This block sits in the decode stage of a five-stage in-order pipeline. It finds the one data dependency that forwarding cannot cover: a load in execute whose destination register is a source operand of the instruction now in decode. When it finds one, it freezes the program counter and the fetch/decode register for one cycle. In the same cycle it sends an empty control bundle into the execute stage in place of the decoded one. The dependent instruction then repeats its decode one cycle later, and by that time the loaded value can be forwarded.

The block also owns the control part of the decode/execute pipeline register. Each cycle it registers either the decoded control bundle or all zeros. The datapath fields of that register stay outside the block. The load flag it tests comes from its own registered bundle, so the hazard releases by itself: once a bubble has been inserted, execute holds a no-op whose load flag is clear.

Top module: `luse_stall_ctrl`

## Requirements
- R1: When the registered execute bundle has its load flag (bit 6) set, the execute destination is non-zero and equals the decode first source, `pc_we_o` and `ifid_we_o` are 0 in that same cycle.
- R2: The same hold occurs when the non-zero execute destination equals the decode second source instead.
- R3: When the execute load flag is clear, both enables are 1 whatever the register numbers are.
- R4: An execute destination of register 0 never causes a hold, even with the load flag set and matching sources.
- R5: After a cycle with a hold, `ex_ctl_o` is all zeros on all 9 bits. The bit order, high to low, is: write-back enable, memory-to-register select, load flag, store flag, branch, destination select, immediate-operand select, 2-bit ALU operation.
- R6: After a cycle without a hold, `ex_ctl_o` equals the `dec_ctl_i` value that was present in that cycle.
- R7: A hold lasts one cycle only. If the inputs are kept unchanged after a hold, the enables return to 1 and the repeated instruction's bundle is registered on the next edge.
- R8: While reset is asserted and right after it is released, `ex_ctl_o` is zero and both enables are 1.
- R9: `pc_we_o` and `ifid_we_o` are equal in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_rt_i | input | REG_AW | Destination register of the instruction in execute (the load target) |
| dec_rs_i | input | REG_AW | First source register of the instruction in decode |
| dec_rt_i | input | REG_AW | Second source register of the instruction in decode |
| dec_ctl_i | input | 9 | Decoded control bundle of the instruction in decode |
| pc_we_o | output | 1 | Program-counter write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| ex_ctl_o | output | 9 | Registered control bundle of the decode/execute register |

## Verification
Hold detection and bundle registration happen in the same cycle. The hard case is when the instruction in decode is itself a load that depends on the load in execute: its load flag must be replaced by zero. If it were not, the hold would keep re-arming. The bench sweeps every pairing of load flag, destination and both sources over a reduced 3-bit register index, with bundles that carry the load flag as well as without it. For each hold it checks that the enables drop in that cycle, that the bubble is registered as all zeros, and that on the following edge the enables come back and the repeated bundle, load flag included, is registered.

// File: rtl/luse_pkg.sv
package luse_pkg;

  typedef struct packed {
    logic       wb_en;
    logic       mem2reg;
    logic       ld_flag;
    logic       st_flag;
    logic       br_en;
    logic       dst_sel;
    logic       imm_sel;
    logic [1:0] alu_op;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  function automatic logic reg_hit(input logic [7:0] dst, input logic [7:0] src_a,
                                   input logic [7:0] src_b);
    return (dst == src_a) || (dst == src_b);
  endfunction

endpackage

// File: rtl/luse_hazard_det.sv
module luse_hazard_det #(
  parameter int REG_AW      = 5,
  parameter bit ZERO_EXEMPT = 1'b1
) (
  input  logic              ld_pending_i,
  input  logic [REG_AW-1:0] ld_dst_i,
  input  logic [REG_AW-1:0] src_a_i,
  input  logic [REG_AW-1:0] src_b_i,
  output logic              stall_o
);
  localparam int PAD = 8 - REG_AW;

  logic src_match;
  logic dst_valid;

  assign src_match = luse_pkg::reg_hit({{PAD{1'b0}}, ld_dst_i},
                                       {{PAD{1'b0}}, src_a_i},
                                       {{PAD{1'b0}}, src_b_i});

  generate
    if (ZERO_EXEMPT) begin : g_zero_exempt
      assign dst_valid = |ld_dst_i;
    end else begin : g_any_dst
      assign dst_valid = 1'b1;
    end
  endgenerate

  assign stall_o = ld_pending_i & dst_valid & src_match;
endmodule

// File: rtl/luse_ctl_stage.sv
module luse_ctl_stage (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            squash_i,
  input  luse_pkg::ctl_t  ctl_i,
  output luse_pkg::ctl_t  ctl_q_o
);
  luse_pkg::ctl_t ctl_next;

  always_comb begin
    ctl_next = squash_i ? '0 : ctl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q_o <= '0;
    else        ctl_q_o <= ctl_next;
  end
endmodule

// File: rtl/luse_front_hold.sv
module luse_front_hold (
  input  logic stall_i,
  output logic pc_we_o,
  output logic ifid_we_o
);
  assign pc_we_o   = ~stall_i;
  assign ifid_we_o = ~stall_i;
endmodule

// File: rtl/luse_stall_ctrl.sv
module luse_stall_ctrl #(
  parameter int REG_AW      = 5,
  parameter bit ZERO_EXEMPT = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [REG_AW-1:0]          ex_rt_i,
  input  logic [REG_AW-1:0]          dec_rs_i,
  input  logic [REG_AW-1:0]          dec_rt_i,
  input  logic [luse_pkg::CTL_W-1:0] dec_ctl_i,
  output logic                       pc_we_o,
  output logic                       ifid_we_o,
  output logic [luse_pkg::CTL_W-1:0] ex_ctl_o
);
  luse_pkg::ctl_t ex_ctl_q;
  luse_pkg::ctl_t dec_ctl;
  logic           hz_stall;

  assign dec_ctl = luse_pkg::ctl_t'(dec_ctl_i);

  luse_hazard_det #(.REG_AW(REG_AW), .ZERO_EXEMPT(ZERO_EXEMPT)) det_i (
    .ld_pending_i (ex_ctl_q.ld_flag),
    .ld_dst_i     (ex_rt_i),
    .src_a_i      (dec_rs_i),
    .src_b_i      (dec_rt_i),
    .stall_o      (hz_stall)
  );

  luse_ctl_stage ctl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .squash_i (hz_stall),
    .ctl_i    (dec_ctl),
    .ctl_q_o  (ex_ctl_q)
  );

  luse_front_hold hold_i (
    .stall_i   (hz_stall),
    .pc_we_o   (pc_we_o),
    .ifid_we_o (ifid_we_o)
  );

  assign ex_ctl_o = ex_ctl_q;
endmodule

// File: rtl/luse_stall_ctrl_chk.sv
module luse_stall_ctrl_chk #(
  parameter int REG_AW = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       stall_w,
  input logic [REG_AW-1:0]          ex_rt_i,
  input logic [luse_pkg::CTL_W-1:0] dec_ctl_i,
  input logic                       pc_we_o,
  input logic                       ifid_we_o,
  input logic [luse_pkg::CTL_W-1:0] ex_ctl_o
);
  // R3
  no_load_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_ctl_o[6] |-> pc_we_o);
  // R4
  zero_dst_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rt_i == '0) |-> pc_we_o);
  // R5
  bubble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_w |=> (ex_ctl_o == '0));
  // R6
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_w |=> (ex_ctl_o == $past(dec_ctl_i)));
  // R7
  single_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_w |=> !stall_w);
  // R8
  reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ex_ctl_o == '0) && pc_we_o);
  // R9
  enables_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we_o == ifid_we_o);
endmodule

bind luse_stall_ctrl luse_stall_ctrl_chk #(.REG_AW(REG_AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .stall_w   (hz_stall),
  .ex_rt_i   (ex_rt_i),
  .dec_ctl_i (dec_ctl_i),
  .pc_we_o   (pc_we_o),
  .ifid_we_o (ifid_we_o),
  .ex_ctl_o  (ex_ctl_o)
);

// File: tb/luse_stall_ctrl_tb.sv
module luse_stall_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int NREG = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ex_rt = '0;
  logic [AW-1:0] dec_rs = '0;
  logic [AW-1:0] dec_rt = '0;
  logic [8:0]    dec_ctl = '0;
  logic          pc_we;
  logic          ifid_we;
  logic [8:0]    ex_ctl;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  luse_stall_ctrl #(.REG_AW(AW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ex_rt_i   (ex_rt),
    .dec_rs_i  (dec_rs),
    .dec_rt_i  (dec_rt),
    .dec_ctl_i (dec_ctl),
    .pc_we_o   (pc_we),
    .ifid_we_o (ifid_we),
    .ex_ctl_o  (ex_ctl)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int idx = 0;
    @(negedge clk);
    // R8: state during reset
    chk("R8 ctl in reset", {7'd0, ex_ctl}, 16'd0);
    chk("R8 pc_we in reset", {15'd0, pc_we}, 16'd1);
    chk("R8 ifid_we in reset", {15'd0, ifid_we}, 16'd1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8 ctl after release", {7'd0, ex_ctl}, 16'd0);
    chk("R8 pc_we after release", {15'd0, pc_we}, 16'd1);

    for (int m = 0; m < 2; m++) begin
      for (int r = 0; r < NREG; r++) begin
        for (int a = 0; a < NREG; a++) begin
          for (int b = 0; b < NREG; b++) begin
            logic [8:0] c_bun;
            logic [8:0] d_bun;
            logic       st;
            idx++;
            c_bun = 9'((idx * 53 + 11) & 9'h1BF) | 9'(m << 6);
            d_bun = 9'((idx * 29 + 3) & 9'h1FF);
            st = (m == 1) && (r != 0) && ((r == a) || (r == b));
            // loading cycle: ex destination 0 keeps any prior load harmless (R4)
            @(negedge clk);
            ex_rt = '0; dec_rs = AW'(a); dec_rt = AW'(b); dec_ctl = c_bun;
            #1;
            chk("R4 zero destination", {15'd0, pc_we}, 16'd1);
            @(negedge clk);
            chk("R6 bundle registered", {7'd0, ex_ctl}, {7'd0, c_bun});
            ex_rt = AW'(r); dec_rs = AW'(a); dec_rt = AW'(b); dec_ctl = d_bun;
            #1;
            if (m == 0)
              chk("R3 no load flag", {15'd0, pc_we}, 16'd1);
            else if (r == 0)
              chk("R4 zero destination", {15'd0, pc_we}, 16'd1);
            else if (r == a)
              chk("R1 first source hit", {15'd0, pc_we}, {15'd0, !st});
            else if (r == b)
              chk("R2 second source hit", {15'd0, pc_we}, {15'd0, !st});
            else
              chk("R1 R2 miss", {15'd0, pc_we}, 16'd1);
            chk("R9 enables agree", {15'd0, ifid_we}, {15'd0, pc_we});
            @(negedge clk);
            if (st) begin
              chk("R5 bubble zero", {7'd0, ex_ctl}, 16'd0);
              #1;
              chk("R7 hold released", {15'd0, pc_we}, 16'd1);
              chk("R9 enables agree", {15'd0, ifid_we}, 16'd1);
              @(negedge clk);
              chk("R7 repeated bundle", {7'd0, ex_ctl}, {7'd0, d_bun});
            end else begin
              chk("R6 pass through", {7'd0, ex_ctl}, {7'd0, d_bun});
            end
          end
        end
      end
    end

    // R8: reset mid-run clears a loaded bundle
    @(negedge clk);
    ex_rt = '0; dec_ctl = 9'h1FF;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 ctl cleared by reset", {7'd0, ex_ctl}, 16'd0);
    chk("R8 pc_we in reset", {15'd0, pc_we}, 16'd1);
    finish_run();
  end
endmodule